// File: doc/BRIEF.md
# ISA I/O Recovery Delay Controller

This block keeps a programmable idle gap between one ISA I/O command and the next, so that a slow add-in card is not overrun by a following write. It sits in front of the ISA cycle engine. A command request comes in with two flags. One flag marks an I/O cycle and the other marks an I/O cycle as general purpose. The block answers with `go`, which lets the engine start the cycle, or with `hold`, which keeps the request waiting. The engine reports the end of each cycle with `cmd_done`.

When an I/O command ends, a down counter is loaded with the 4-bit recovery length, or with zero if the master recovery enable is clear. It then counts down once per ISA clock, marked by the `isa_tick` strobe. A later I/O request is held while the counter is non-zero, but only if the master enable is set and the enable for that request's class is set. The classes are on-chip decoded ports and general-purpose ports. Memory requests always pass at once and never load the counter. The engine runs one command at a time, and no grant is given while a command is in flight.

The control is a four-state machine:
- `ST_IDLE`: no command is running.
- `ST_HOLD`: an I/O request is waiting out recovery.
- `ST_RUN_IO`: an I/O command is in flight.
- `ST_RUN_MEM`: a memory command is in flight.

Its transitions are:
- From IDLE or HOLD to RUN_IO or RUN_MEM on a grant.
- From IDLE to HOLD when a request is blocked.
- From HOLD back to IDLE when the request is withdrawn.
- From RUN_IO or RUN_MEM to IDLE on `cmd_done`. Only the exit from RUN_IO loads the counter.

Top module: `iorcv_ctrl`

## Requirements
- R1: With reset asserted and no request, `go` and `hold` are both 0. The first I/O request after reset is granted in the same cycle it is presented.
- R2: After an I/O command ends with master enable set, length N≠0 and the next request's class enable set, that next I/O request sees `hold`=1 and `go`=0 for exactly N ISA ticks before `go` rises. N may be anywhere from 1 to 15.
- R3: A recovery length of 0 adds no delay, and the next I/O request is granted at once.
- R4: With the master enable (`cfg_rcv_on`) at 0, the length field has no effect, and I/O requests are never held.
- R5: An I/O request with `req_gp`=0 is on-chip decoded. Its recovery is applied only when `cfg_onchip_on`=1, whatever the value of `cfg_gp_on`.
- R6: An I/O request with `req_gp`=1 is general purpose. Its recovery is applied only when `cfg_gp_on`=1, whatever the value of `cfg_onchip_on`.
- R7: A memory request (`req_io`=0) is granted at once, even while recovery is pending.
- R8: `hold` is high only while an I/O request is waiting, and `go` and `hold` are never high together.
- R9: No grant is given while a command is in flight, that is, after a grant and up to its `cmd_done`.
- R10: The recovery counter moves only on cycles where `isa_tick`=1. With a divided tick, the hold spans N ticks, not N clocks.
- R11: The end of a memory command does not start a recovery period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isa_tick | input | 1 | One-cycle strobe per ISA clock period |
| cfg_rcv_len | input | CNT_W (4) | Recovery length in ISA clocks |
| cfg_rcv_on | input | 1 | Master recovery enable |
| cfg_onchip_on | input | 1 | Apply recovery to on-chip decoded I/O |
| cfg_gp_on | input | 1 | Apply recovery to general-purpose I/O |
| req_valid | input | 1 | Command request, held until `go` |
| req_io | input | 1 | 1 = I/O command, 0 = memory command |
| req_gp | input | 1 | For I/O: 1 = general purpose, 0 = on-chip decoded |
| cmd_done | input | 1 | One-cycle pulse marking the end of the running command |
| go | output | 1 | Grant: the engine may start the requested command |
| hold | output | 1 | The request is waiting out recovery |

## Verification
The assertions take three things for granted about the engine side. A request stays raised with steady flags until `go` is seen. `cmd_done` arrives only while a granted command is running. The configuration inputs do not change while a request is being held. The bench drives requests from tasks that keep them raised and steady until the grant and drop them right after it. It pulses `cmd_done` once per command, and it changes the configuration only between commands, when no request is pending.

// File: rtl/iorcv_pkg.sv
package iorcv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_RUN_IO  = 2'd2,
        ST_RUN_MEM = 2'd3
    } rcv_state_t;

endpackage

// File: rtl/iorcv_counter.sv
module iorcv_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // A load takes priority; otherwise step down once per ISA tick, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != CNT_ZERO)) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign expired = (cnt_q == CNT_ZERO);

    // The count is frozen between ISA ticks.
    assert_cnt_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));

    // Each tick removes exactly one ISA period of recovery.
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && !expired) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

endmodule

// File: rtl/iorcv_gate.sv
module iorcv_gate (
    input  logic req_io,
    input  logic req_gp,
    input  logic rcv_on,
    input  logic onchip_on,
    input  logic gp_on,
    input  logic expired,
    output logic block
);
    logic class_on;

    // The class of the waiting request picks the enable that applies to it.
    always_comb begin
        class_on = req_gp ? gp_on : onchip_on;
        block    = req_io && rcv_on && class_on && !expired;
    end

endmodule

// File: rtl/iorcv_fsm.sv
module iorcv_fsm
    import iorcv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_io,
    input  logic block,
    input  logic cmd_done,
    output logic go,
    output logic hold,
    output logic io_end
);
    rcv_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (!req_valid)  state_d = ST_IDLE;
                else if (block)  state_d = ST_HOLD;
                else if (req_io) state_d = ST_RUN_IO;
                else             state_d = ST_RUN_MEM;
            end
            ST_RUN_IO:  if (cmd_done) state_d = ST_IDLE;
            ST_RUN_MEM: if (cmd_done) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        go     = 1'b0;
        hold   = 1'b0;
        io_end = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                go   = req_valid && !block;
                hold = req_valid && block;
            end
            ST_RUN_IO:  io_end = cmd_done;
            ST_RUN_MEM: io_end = 1'b0;
        endcase
    end

    assert_go_hold_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(go && hold));

    assert_hold_only_io_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (req_valid && req_io));

    assert_no_go_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN_IO) || (state_q == ST_RUN_MEM)) |-> !go);

    assert_mem_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io && ((state_q == ST_IDLE) || (state_q == ST_HOLD))) |-> go);

endmodule

// File: rtl/iorcv_ctrl.sv
module iorcv_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             isa_tick,
    input  logic [CNT_W-1:0] cfg_rcv_len,
    input  logic             cfg_rcv_on,
    input  logic             cfg_onchip_on,
    input  logic             cfg_gp_on,
    input  logic             req_valid,
    input  logic             req_io,
    input  logic             req_gp,
    input  logic             cmd_done,
    output logic             go,
    output logic             hold
);
    localparam logic [CNT_W-1:0] LEN_NONE = '0;

    logic             io_end;
    logic             expired;
    logic             block;
    logic [CNT_W-1:0] load_val;

    // With the master enable clear the length field is ignored entirely.
    assign load_val = cfg_rcv_on ? cfg_rcv_len : LEN_NONE;

    iorcv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (io_end),
        .load_val (load_val),
        .tick     (isa_tick),
        .expired  (expired)
    );

    iorcv_gate u_gate (
        .req_io    (req_io),
        .req_gp    (req_gp),
        .rcv_on    (cfg_rcv_on),
        .onchip_on (cfg_onchip_on),
        .gp_on     (cfg_gp_on),
        .expired   (expired),
        .block     (block)
    );

    iorcv_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_io    (req_io),
        .block     (block),
        .cmd_done  (cmd_done),
        .go        (go),
        .hold      (hold),
        .io_end    (io_end)
    );

    assert_master_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rcv_on |-> !hold);

    assert_len_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_end && (cfg_rcv_len == LEN_NONE)) |=> !hold);

endmodule

// File: tb/sim_iorcv_ctrl.sv
module sim_iorcv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       isa_tick = 1'b1;
    logic [3:0] len = 4'd0;
    logic       rcv_on = 1'b0, oc_on = 1'b0, gp_on = 1'b0;
    logic       req_valid = 1'b0, req_io = 1'b0, req_gp = 1'b0, cmd_done = 1'b0;
    logic       go, hold;

    int n_chk = 0;
    int n_err = 0;
    int tick_div = 1;
    int tick_ph = 0;
    int hold_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tick_ph = (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
        isa_tick <= (tick_ph == 0);
    end

    iorcv_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .isa_tick(isa_tick), .cfg_rcv_len(len),
        .cfg_rcv_on(rcv_on), .cfg_onchip_on(oc_on), .cfg_gp_on(gp_on),
        .req_valid(req_valid), .req_io(req_io), .req_gp(req_gp),
        .cmd_done(cmd_done), .go(go), .hold(hold)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present a request, wait for go, count ISA ticks and clocks spent waiting.
    task automatic issue(input bit io, input bit gp, output int ticks, output int cycles);
        req_valid = 1'b1; req_io = io; req_gp = gp;
        #1;
        ticks = 0; cycles = 0;
        while (!go && cycles < 500) begin
            if (!hold) hold_bad++;
            @(posedge clk);
            if (isa_tick) ticks++;
            cycles++;
            @(negedge clk); #1;
        end
        if (hold) hold_bad++;
        @(posedge clk);
        @(negedge clk); #1;
        req_valid = 1'b0; req_io = 1'b0; req_gp = 1'b0;
    endtask

    task automatic finish_cmd(input int busy);
        repeat (busy) begin @(negedge clk); #1; end
        cmd_done = 1'b1;
        @(negedge clk); #1;
        cmd_done = 1'b0;
    endtask

    task automatic set_cfg(input int l, input bit m, input bit oc, input bit gp);
        len = 4'(l); rcv_on = m; oc_on = oc; gp_on = gp;
    endtask

    // A primer I/O command ends, then the measured I/O request follows at once.
    task automatic io_pair(input bit gp, input int exp, input string req);
        int t, c;
        issue(1'b1, 1'b0, t, c);
        finish_cmd(2);
        hold_bad = 0;
        issue(1'b1, gp, t, c);
        check(t == exp, req, t, exp);
        check(hold_bad == 0, {req, " hold/go while waiting"}, hold_bad, 0);
        finish_cmd(1);
    endtask

    task automatic t_reset();
        int t, c;
        @(negedge clk); #1;
        check(go == 1'b0, "R1 go in reset", go, 0);
        check(hold == 1'b0, "R1 hold in reset", hold, 0);
        rst_n = 1'b1;
        set_cfg(7, 1, 1, 1);
        @(negedge clk); #1;
        issue(1'b1, 1'b0, t, c);
        check(t == 0 && c == 0, "R1 first io immediate", c, 0);
        finish_cmd(1);
    endtask

    task automatic t_basic();
        set_cfg(3, 1, 1, 1);  io_pair(1'b0, 3,  "R2 len3 onchip");
        set_cfg(15, 1, 1, 1); io_pair(1'b0, 15, "R2 len15 onchip");
        set_cfg(1, 1, 1, 1);  io_pair(1'b1, 1,  "R2 len1 gp");
    endtask

    task automatic t_len0();
        set_cfg(0, 1, 1, 1);  io_pair(1'b0, 0, "R3 len0");
    endtask

    task automatic t_master_off();
        set_cfg(9, 0, 1, 1);  io_pair(1'b0, 0, "R4 master off onchip");
        set_cfg(9, 0, 1, 1);  io_pair(1'b1, 0, "R4 master off gp");
    endtask

    task automatic t_onchip_class();
        set_cfg(6, 1, 0, 1);  io_pair(1'b0, 0, "R5 onchip off");
        set_cfg(4, 1, 1, 0);  io_pair(1'b0, 4, "R5 onchip on gp off");
    endtask

    task automatic t_gp_class();
        set_cfg(5, 1, 1, 0);  io_pair(1'b1, 0, "R6 gp off");
        set_cfg(5, 1, 0, 1);  io_pair(1'b1, 5, "R6 gp on onchip off");
    endtask

    task automatic t_tick_div();
        int t, c;
        set_cfg(4, 1, 1, 1);
        issue(1'b1, 1'b0, t, c);
        tick_div = 3;
        finish_cmd(2);
        issue(1'b1, 1'b0, t, c);
        check(t == 4, "R10 ticks with divided clock", t, 4);
        check(c >= 10, "R10 clocks with divided clock", c, 10);
        finish_cmd(1);
        tick_div = 1;
        repeat (4) begin @(negedge clk); #1; end
    endtask

    task automatic t_mem();
        int t, c;
        set_cfg(10, 1, 1, 1);
        issue(1'b1, 1'b0, t, c);
        finish_cmd(1);
        hold_bad = 0;
        issue(1'b0, 1'b0, t, c);
        check(c == 0, "R7 mem during recovery", c, 0);
        check(hold_bad == 0, "R7 mem never held", hold_bad, 0);
        finish_cmd(12);
    endtask

    task automatic t_mem_end();
        int t, c;
        set_cfg(0, 1, 1, 1);
        issue(1'b1, 1'b0, t, c);
        finish_cmd(1);
        set_cfg(10, 1, 1, 1);
        issue(1'b0, 1'b0, t, c);
        finish_cmd(1);
        issue(1'b1, 1'b0, t, c);
        check(c == 0, "R11 mem end starts no recovery", c, 0);
        finish_cmd(1);
    endtask

    task automatic t_busy();
        int t, c;
        set_cfg(0, 1, 1, 1);
        issue(1'b0, 1'b0, t, c);
        req_valid = 1'b1; req_io = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(go == 1'b0, "R9 no grant while running", go, 0);
            check(hold == 1'b0, "R8 no hold for mem", hold, 0);
            @(negedge clk); #1;
        end
        req_valid = 1'b0;
        finish_cmd(0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_basic();
        t_len0();
        t_master_off();
        t_onchip_class();
        t_gp_class();
        t_tick_div();
        t_mem();
        t_mem_end();
        t_busy();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule